// File: doc/BRIEF.md
# Memory Access Responder with Abort Handling

This block sits between a processor's bus request port and the memory back end. Each request is sorted by the upper address bits into one of four classes: a reserved window, one of the static chip-select banks, one of the DRAM banks, or empty space. The class decides the response. The requester may get read data, a data abort, a write that is silently dropped, or, for a DRAM bank that is not enabled, a refresh cycle to every DRAM bank. A last-bus-value register supplies the read data when no device answers.

Every accepted request follows the same three-state path: accept, access, respond. During the access cycle the block drives active-low strobes toward memory and samples back-end read data. In the respond cycle it raises a one-cycle `done` with `rdata` and `abort`. Software loads the DRAM bank enables through a load strobe. Two strap inputs fix the boot ROM configuration while reset is held. Out of reset, every memory strobe is in its inactive state.

Top module: `mem_abort_resp`

## Requirements
- R1: A read whose slot lies in the reserved window completes with `abort`=1 and `rdata`=0. No memory strobe is driven and no refresh is requested. The reserved window is checked before every other region, so it wins where ranges overlap.
- R2: A write to the reserved window completes with `abort`=0 and drives no strobe. It leaves the last-bus-value register unchanged.
- R3: An access to a slot that is in no region drives no strobe, requests no refresh and never aborts. A write there has no effect.
- R4: The last-bus-value register resets to zero. It takes the back-end data on every read of an enabled bank and the write data on every write to an enabled bank. A read of empty space returns its current value.
- R5: A non-burst access, or any write, to a DRAM bank whose enable bit is 0 raises `refresh_req` for exactly the access cycle. In that same cycle all `ras_n` and all `cas_n` are low, and `done` follows in the next cycle.
- R6: That disabled-bank access returns `rdata`=0 with `abort`=0 on a read. On a write it drives no write enable and leaves the last-bus-value register unchanged.
- R7: A burst read (`req_burst`=1, `req_write`=0) of a disabled DRAM bank completes with `abort`=1, `rdata`=0 and no refresh or strobe.
- R8: An access to a static bank, or to an enabled DRAM bank, lowers only that bank's `cs_n` (static) or `ras_n` (DRAM) during the access cycle. For DRAM all `cas_n` also go low. A read drives `oe_n`=0 and `rd_nwr`=1, a write drives `we_n`=0, and a read returns `be_rdata` as sampled in the access cycle.
- R9: `req_ready` is high only when idle. A request accepted on edge N yields the access cycle after N and a single-cycle `done` after edge N+1.
- R10: While `rst_n` is low and after reset, with no access in progress: all `cs_n`, `ras_n` and `cas_n` are high, `oe_n`=1, `we_n`=1, `rd_nwr`=0, `done`=0 and `refresh_req`=0.
- R11: `boot_cfg` takes its value while reset is held: 2'b10 when `strap_smrom`=1, otherwise 2'b00 when `strap_rom32`=0 (16-bit) and 2'b01 when it is 1 (32-bit). Strap changes after reset have no effect.
- R12: All DRAM bank enables reset to 0. A cycle with `en_load`=1 replaces them with `en_value` (bit i enables DRAM bank i). The new value governs requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Request is a burst |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion |
| abort | output | 1 | Data abort, valid with done |
| rdata | output | DW | Read data, valid with done |
| en_load | input | 1 | Load DRAM bank enables |
| en_value | input | NDRAM | New bank enable bits |
| mem_addr | output | AW | Captured address to back end |
| mem_wdata | output | DW | Captured write data to back end |
| be_rdata | input | DW | Back-end read data, sampled in the access cycle |
| refresh_req | output | 1 | All-bank refresh pulse |
| ras_n | output | NDRAM | DRAM row strobe / chip select, active low |
| cas_n | output | NDRAM | DRAM column strobe / byte mask, active low |
| cs_n | output | NSTATIC | Static chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| rd_nwr | output | 1 | Direction: 1 during a read |
| strap_smrom | input | 1 | Boot from synchronous mask ROM |
| strap_rom32 | input | 1 | Asynchronous boot ROM width: 1 = 32 bit |
| boot_cfg | output | 2 | Boot ROM configuration code |

## Verification
The bench builds the block with an 8-bit address and 16-byte slots. That gives sixteen slots: six static, four DRAM, a reserved window over slots 5 to 7 that overlaps the last static slot, and four empty slots. With so few slots, every address can be swept as both a read and a write, burst and non-burst, under three bank-enable patterns. This covers the reserved-over-static priority and each DRAM bank both enabled and disabled. Reset is repeated with all strap combinations, which makes every boot code and the clearing of enables and last value reachable.

// File: rtl/mar_pkg.sv
// Shared types for the memory access responder.
// Assumes: region and kind codes are internal only; boot codes are visible on boot_cfg.
package mar_pkg;
    typedef enum logic [1:0] {REG_NONE, REG_RSV, REG_STATIC, REG_DRAM} region_e;
    typedef enum logic [2:0] {K_ACCESS, K_REFRESH, K_ABORT, K_DROP, K_LAST} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_ACC, S_RESP} state_e;
    localparam logic [1:0] BOOT_ASYNC16 = 2'b00;
    localparam logic [1:0] BOOT_ASYNC32 = 2'b01;
    localparam logic [1:0] BOOT_SMROM   = 2'b10;
endpackage

// File: rtl/mar_decode.sv
// Address-slot decoder: maps the slot number (upper address bits) to a region and bank index.
// Assumes: the reserved window is tested first, empty space is whatever remains.
module mar_decode
    import mar_pkg::*;
#(
    parameter int SLW          = 4,
    parameter int NSTATIC      = 6,
    parameter int NDRAM        = 4,
    parameter int STATIC_FIRST = 0,
    parameter int DRAM_FIRST   = 8,
    parameter int RSV_FIRST    = 5,
    parameter int RSV_LAST     = 7,
    parameter int SW           = 3,
    parameter int DRW          = 2
) (
    input  logic [SLW-1:0] slot,
    output region_e        region,
    output logic [SW-1:0]  st_idx,
    output logic [DRW-1:0] dr_idx
);
    logic [31:0] s32;

    // Purpose: priority compare of the slot against the parameter ranges.
    always_comb begin
        s32    = 32'(slot);
        st_idx = SW'(s32 - 32'(STATIC_FIRST));
        dr_idx = DRW'(s32 - 32'(DRAM_FIRST));
        if (s32 >= 32'(RSV_FIRST) && s32 <= 32'(RSV_LAST))
            region = REG_RSV;
        else if (s32 >= 32'(STATIC_FIRST) && s32 < 32'(STATIC_FIRST + NSTATIC))
            region = REG_STATIC;
        else if (s32 >= 32'(DRAM_FIRST) && s32 < 32'(DRAM_FIRST + NDRAM))
            region = REG_DRAM;
        else
            region = REG_NONE;
    end
endmodule

// File: rtl/mar_seq.sv
// Request sequencer: accepts one request at a time, classifies it, runs the
// access cycle and returns a one-cycle response. Holds bank enables and last bus value.
// Assumes: be_rdata is valid during the access cycle; en_load may come at any time.
module mar_seq
    import mar_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NDRAM = 4,
    parameter int SW    = 3,
    parameter int DRW   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_burst,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  region_e          region,
    input  logic [SW-1:0]    st_idx,
    input  logic [DRW-1:0]   dr_idx,
    input  logic             en_load,
    input  logic [NDRAM-1:0] en_value,
    input  logic [DW-1:0]    be_rdata,
    output logic             req_ready,
    output logic             done,
    output logic             abort,
    output logic [DW-1:0]    rdata,
    output logic             refresh_req,
    output logic             acc,
    output kind_e            kind_q,
    output logic             write_q,
    output region_e          region_q,
    output logic [SW-1:0]    st_q,
    output logic [DRW-1:0]   dr_q,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata
);
    state_e           state_q;
    kind_e            kind_d;
    logic [NDRAM-1:0] en_q;
    logic [DW-1:0]    last_q;
    logic [DW-1:0]    rdata_q;
    logic             abort_q;
    logic             take;

    assign take = (state_q == S_IDLE) && req_valid;

    // Purpose: choose the response kind for the incoming request.
    always_comb begin
        unique case (region)
            REG_RSV:    kind_d = req_write ? K_DROP : K_ABORT;
            REG_STATIC: kind_d = K_ACCESS;
            REG_DRAM:   kind_d = en_q[dr_idx] ? K_ACCESS :
                                 ((!req_write && req_burst) ? K_ABORT : K_REFRESH);
            default:    kind_d = req_write ? K_DROP : K_LAST;
        endcase
    end

    // Purpose: three-state handshake, idle -> access -> respond.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else begin
            unique case (state_q)
                S_IDLE:  if (req_valid) state_q <= S_ACC;
                S_ACC:   state_q <= S_RESP;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Purpose: capture the accepted request and its classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_DROP;
            write_q   <= 1'b0;
            region_q  <= REG_NONE;
            st_q      <= '0;
            dr_q      <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (take) begin
            kind_q    <= kind_d;
            write_q   <= req_write;
            region_q  <= region;
            st_q      <= st_idx;
            dr_q      <= dr_idx;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
        end
    end

    // Purpose: DRAM bank enable bits, cleared by reset, replaced by a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_load) en_q <= en_value;
    end

    // Purpose: form the response and update the last bus value in the access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            abort_q <= 1'b0;
            last_q  <= '0;
        end else if (state_q == S_ACC) begin
            rdata_q <= '0;
            abort_q <= (kind_q == K_ABORT);
            if (kind_q == K_ACCESS) begin
                if (write_q) last_q <= mem_wdata;
                else begin
                    rdata_q <= be_rdata;
                    last_q  <= be_rdata;
                end
            end else if (kind_q == K_LAST && !write_q) begin
                rdata_q <= last_q;
            end
        end
    end

    assign req_ready   = (state_q == S_IDLE);
    assign acc         = (state_q == S_ACC);
    assign done        = (state_q == S_RESP);
    assign abort       = done && abort_q;
    assign rdata       = rdata_q;
    assign refresh_req = acc && (kind_q == K_REFRESH);

    assert_refresh_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> (!refresh_req && done));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !done));
    assert_abort_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (done && rdata == '0));
    assert_enables_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));
endmodule

// File: rtl/mar_pins.sv
// Memory pin driver: turns the sequencer's access-cycle state into active-low strobes,
// and latches the boot ROM configuration from straps while reset is held.
// Assumes: strobes are decoded from registered state only, so they follow clock edges.
module mar_pins
    import mar_pkg::*;
#(
    parameter int NSTATIC = 6,
    parameter int NDRAM   = 4,
    parameter int SW      = 3,
    parameter int DRW     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  kind_e              kind,
    input  logic               write,
    input  region_e            region,
    input  logic [SW-1:0]      st_idx,
    input  logic [DRW-1:0]     dr_idx,
    input  logic               strap_smrom,
    input  logic               strap_rom32,
    output logic [NSTATIC-1:0] cs_n,
    output logic [NDRAM-1:0]   ras_n,
    output logic [NDRAM-1:0]   cas_n,
    output logic               oe_n,
    output logic               we_n,
    output logic               rd_nwr,
    output logic [1:0]         boot_cfg
);
    logic hit_st, hit_dr, refresh, xfer;

    // Purpose: decide which kind of cycle appears on the pins.
    always_comb begin
        hit_st  = acc && (kind == K_ACCESS) && (region == REG_STATIC);
        hit_dr  = acc && (kind == K_ACCESS) && (region == REG_DRAM);
        refresh = acc && (kind == K_REFRESH);
        xfer    = hit_st || hit_dr;
    end

    for (genvar g = 0; g < NSTATIC; g++) begin : g_cs
        assign cs_n[g] = !(hit_st && (st_idx == SW'(g)));
    end
    for (genvar g = 0; g < NDRAM; g++) begin : g_ras
        assign ras_n[g] = !((hit_dr && (dr_idx == DRW'(g))) || refresh);
    end

    assign cas_n  = (hit_dr || refresh) ? '0 : '1;
    assign oe_n   = !(xfer && !write);
    assign we_n   = !(xfer && write);
    assign rd_nwr = xfer && !write;

    // Purpose: follow the straps during reset, hold the code afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_cfg <= strap_smrom ? BOOT_SMROM :
                                (strap_rom32 ? BOOT_ASYNC32 : BOOT_ASYNC16);
    end

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (&cs_n && &ras_n && &cas_n && oe_n && we_n && !rd_nwr));
    assert_one_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_boot_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_cfg));
endmodule

// File: rtl/mem_abort_resp.sv
// Top of the memory access responder: decoder, sequencer and pin driver.
// Assumes: region boundaries are given as slot numbers of size 2**BANK_LG bytes;
// NSTATIC and NDRAM are at least 2.
module mem_abort_resp
    import mar_pkg::*;
#(
    parameter int AW           = 32,
    parameter int DW           = 32,
    parameter int BANK_LG      = 27,
    parameter int NSTATIC      = 6,
    parameter int NDRAM        = 4,
    parameter int STATIC_FIRST = 0,
    parameter int DRAM_FIRST   = 16,
    parameter int RSV_FIRST    = 6,
    parameter int RSV_LAST     = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_burst,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               done,
    output logic               abort,
    output logic [DW-1:0]      rdata,
    input  logic               en_load,
    input  logic [NDRAM-1:0]   en_value,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      be_rdata,
    output logic               refresh_req,
    output logic [NDRAM-1:0]   ras_n,
    output logic [NDRAM-1:0]   cas_n,
    output logic [NSTATIC-1:0] cs_n,
    output logic               oe_n,
    output logic               we_n,
    output logic               rd_nwr,
    input  logic               strap_smrom,
    input  logic               strap_rom32,
    output logic [1:0]         boot_cfg
);
    localparam int SLW = AW - BANK_LG;
    localparam int SW  = (NSTATIC > 1) ? $clog2(NSTATIC) : 1;
    localparam int DRW = (NDRAM > 1) ? $clog2(NDRAM) : 1;

    region_e        region, region_q;
    kind_e          kind_q;
    logic [SW-1:0]  st_idx, st_q;
    logic [DRW-1:0] dr_idx, dr_q;
    logic           acc, write_q;

    mar_decode #(
        .SLW(SLW), .NSTATIC(NSTATIC), .NDRAM(NDRAM), .STATIC_FIRST(STATIC_FIRST),
        .DRAM_FIRST(DRAM_FIRST), .RSV_FIRST(RSV_FIRST), .RSV_LAST(RSV_LAST),
        .SW(SW), .DRW(DRW)
    ) u_decode (
        .slot(req_addr[AW-1:BANK_LG]), .region(region), .st_idx(st_idx), .dr_idx(dr_idx)
    );

    mar_seq #(.AW(AW), .DW(DW), .NDRAM(NDRAM), .SW(SW), .DRW(DRW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .region(region), .st_idx(st_idx), .dr_idx(dr_idx),
        .en_load(en_load), .en_value(en_value), .be_rdata(be_rdata),
        .req_ready(req_ready), .done(done), .abort(abort), .rdata(rdata),
        .refresh_req(refresh_req), .acc(acc), .kind_q(kind_q), .write_q(write_q),
        .region_q(region_q), .st_q(st_q), .dr_q(dr_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    mar_pins #(.NSTATIC(NSTATIC), .NDRAM(NDRAM), .SW(SW), .DRW(DRW)) u_pins (
        .clk(clk), .rst_n(rst_n), .acc(acc), .kind(kind_q), .write(write_q),
        .region(region_q), .st_idx(st_q), .dr_idx(dr_q),
        .strap_smrom(strap_smrom), .strap_rom32(strap_rom32),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n),
        .rd_nwr(rd_nwr), .boot_cfg(boot_cfg)
    );

    assert_refresh_all_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (ras_n == '0 && cas_n == '0 && oe_n && we_n));
    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(&cs_n && &ras_n && !refresh_req));
endmodule

// File: tb/mem_abort_resp_tb.sv
`timescale 1ns/1ps
module mem_abort_resp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        en_load = 1'b0;
    logic [3:0]  en_value = '0;
    logic        strap_smrom = 1'b0, strap_rom32 = 1'b0;
    logic        req_ready, done, abort, refresh_req, oe_n, we_n, rd_nwr;
    logic [15:0] rdata, mem_wdata, be_rdata;
    logic [7:0]  mem_addr;
    logic [3:0]  ras_n, cas_n;
    logic [5:0]  cs_n;
    logic [1:0]  boot_cfg;

    int errors = 0;
    int checks = 0;
    logic [3:0]  en_m = '0;
    logic [15:0] last_m = '0;

    always #2 clk = ~clk;

    assign be_rdata = 16'(mem_addr) * 16'd37 + 16'h00C5;

    mem_abort_resp #(
        .AW(8), .DW(16), .BANK_LG(4), .NSTATIC(6), .NDRAM(4), .STATIC_FIRST(0),
        .DRAM_FIRST(8), .RSV_FIRST(5), .RSV_LAST(7)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .abort(abort), .rdata(rdata),
        .en_load(en_load), .en_value(en_value), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .be_rdata(be_rdata), .refresh_req(refresh_req),
        .ras_n(ras_n), .cas_n(cas_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .rd_nwr(rd_nwr), .strap_smrom(strap_smrom), .strap_rom32(strap_rom32),
        .boot_cfg(boot_cfg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reset with given straps; checks idle pins (R10) and boot code (R11).
    task automatic do_reset(input bit sm, input bit w32);
        logic [1:0] exp_boot;
        @(negedge clk);
        rst_n = 1'b0; strap_smrom = sm; strap_rom32 = w32;
        repeat (3) @(negedge clk);
        chk("R10 pins in reset", {cs_n, ras_n, cas_n, oe_n, we_n, rd_nwr, refresh_req, done},
            {6'h3F, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        exp_boot = sm ? 2'b10 : {1'b0, w32};
        chk("R10 pins after reset", {cs_n, ras_n, cas_n, oe_n, we_n, rd_nwr, req_ready},
            {6'h3F, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1});
        chk("R11 boot code", boot_cfg, exp_boot);
        strap_smrom = !sm; strap_rom32 = !w32;
        repeat (2) @(negedge clk);
        chk("R11 straps ignored after reset", boot_cfg, exp_boot);
        en_m = '0; last_m = '0;
    endtask

    task automatic load_en(input logic [3:0] v);
        @(negedge clk);
        en_load = 1'b1; en_value = v;
        @(negedge clk);
        en_load = 1'b0;
        en_m = v;
    endtask

    // One request with the full expected pin and response picture.
    task automatic access(input int a, input bit wr, input bit bu);
        int slot = a >> 4;
        bit rsv = (slot >= 5 && slot <= 7);
        bit st  = !rsv && slot < 6;
        bit dr  = !rsv && slot >= 8 && slot <= 11;
        int b   = dr ? slot - 8 : 0;
        bit enb = dr && en_m[b];
        bit dis = dr && !enb;
        bit ab  = (rsv && !wr) || (dis && bu && !wr);
        bit rf  = dis && !ab;
        bit xf  = st || enb;
        bit emp = !rsv && !st && !dr;
        logic [15:0] wd = 16'(a * 91 + 16'h3000);
        logic [15:0] bd = 16'(a) * 16'd37 + 16'h00C5;
        logic [5:0]  ecs = 6'h3F;
        logic [3:0]  eras = 4'hF, ecas = 4'hF;
        logic [15:0] erd;
        string tp, tr;
        if (st) ecs[slot] = 1'b0;
        if (enb) begin eras[b] = 1'b0; ecas = 4'h0; end
        if (rf) begin eras = 4'h0; ecas = 4'h0; end
        erd = (xf && !wr) ? bd : ((emp && !wr) ? last_m : 16'h0);
        if (rsv)      begin tp = wr ? "R2" : "R1"; tr = tp; end
        else if (ab)  begin tp = "R7"; tr = "R7"; end
        else if (rf)  begin tp = "R5"; tr = "R6"; end
        else if (enb) begin tp = "R8"; tr = "R12"; end
        else if (st)  begin tp = "R8"; tr = "R8"; end
        else          begin tp = "R3"; tr = "R4"; end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_burst = bu;
        req_addr = 8'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy in access cycle", {req_ready, done}, 2'b00);
        chk({tp, " access-cycle pins"},
            {refresh_req, cs_n, ras_n, cas_n, oe_n, we_n, rd_nwr, mem_addr},
            {rf, ecs, eras, ecas, !(xf && !wr), !(xf && wr), xf && !wr, 8'(a)});
        @(negedge clk);
        chk({tr, " response"}, {done, abort, refresh_req, rdata}, {1'b1, ab, 1'b0, erd});
        if (xf) last_m = wr ? wd : bd;
        @(negedge clk);
        chk("R9 done one cycle", {done, req_ready}, 2'b01);
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        // R12: enables clear at reset, DRAM single read refreshes and returns zero.
        access(8 * 16 + 3, 1'b0, 1'b0);
        // R4: empty-space read after reset returns zero.
        access(12 * 16, 1'b0, 1'b0);
        foreach (en_m[i]) ;
        for (int p = 0; p < 3; p++) begin
            load_en(p == 0 ? 4'h0 : (p == 1 ? 4'h5 : 4'hA));
            for (int bu = 0; bu < 2; bu++)
                for (int a = 0; a < 256; a++)
                    for (int wr = 0; wr < 2; wr++)
                        access(a, wr[0], bu[0]);
        end
        // R11/R12/R4: reset with every strap combination, then re-check clearing.
        do_reset(1'b0, 1'b1);
        do_reset(1'b1, 1'b0);
        do_reset(1'b1, 1'b1);
        access(9 * 16 + 1, 1'b0, 1'b1);
        access(9 * 16 + 1, 1'b1, 1'b0);
        access(13 * 16 + 2, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule